// File: doc/BRIEF.md
# CCD Horizontal Drive Pulse Generator

This block produces the per-pixel drive pulses for an interline CCD area sensor. The sensor needs two complementary horizontal transfer phases, a second pair of transfer outputs whose phase assignment depends on readout direction, a charge reset pulse, a clamp pulse for correlated double sampling and a sample-hold pulse. A system clock running at `PIX_TICKS` ticks per pixel drives the block. A horizontal pixel counter sets the position of every pulse within the line, and a blanking window marks the pixels where no video is sampled.

Static selects set the line length, the sensor type and the readout direction. The TV standard gives 1212 or 1236 pixels per line. The sensor type moves the start of blanking, and the standard moves its end. In mirror readout the second transfer pair is swapped. An external line reference pulse realigns the counter on its rising edge. The clamp and sample-hold pulses always leave the block on loop outputs. They can drive the final outputs directly, or go out through an external delay and come back on return inputs. The returned pulses then set the final output timing, so the sampling phase can be trimmed.

Top module: `ccd_htg`

## Requirements
- R1: One line is 1212 pixels when `std_pal_i`=0 and 1236 pixels when it is 1, and each pixel is 4 clocks long (`PIX_TICKS`). When the pixel count is at or above the last index of the selected length at the end of a pixel, the next pixel is 0. Consecutive rising edges of `blank_o` are therefore 4848 or 4944 clocks apart.
- R2: `fh1_o` is high during ticks 0 to `PIX_TICKS`/2-1 of each pixel and low during the rest. `fh2_o` is its complement, and the two are never high together.
- R3: When `mirror_i` was 0 at the previous clock edge, `fh1b_o` equals `fh1_o` and `fh2b_o` equals `fh2_o`. When it was 1, `fh1b_o` equals `fh2_o` and `fh2b_o` equals `fh1_o`.
- R4: `rst_pulse_o` is high during the first half of each pixel. The raw clamp pulse is high on tick `PIX_TICKS`/2, and the raw sample pulse is high on the last tick. At most one of the three is high in any cycle.
- R5: `blank_o` is high for pixel counts from the start value (8 when `sens_b_i`=0, 3 when 1) up to but not including the end value (210 when `std_pal_i`=0, 234 when 1).
- R6: While `blank_o` is high, the transfer phases keep toggling once per pixel, and `cds_loop_o` and `sh_loop_o` stay low.
- R7: A clock edge at which `hd_i` is 1, after being 0 at the previous edge, loads pixel 0 tick 0. The pulses for that position appear one edge later, so `blank_o` next rises 1+start×`PIX_TICKS` edges after the realigning edge. Holding `hd_i` high does not realign again.
- R8: When `phase_fix_i`=1, `cds_o` equals `cds_loop_o` and `sh_o` equals `sh_loop_o`. The return inputs have no effect.
- R9: When `phase_fix_i`=0, `cds_o` follows `cds_ret_i` and `sh_o` follows `sh_ret_i` combinationally. A pulse looped back through an external delay of d clocks appears at the output d clocks after the loop output.
- R10: `cds_loop_o` and `sh_loop_o` carry the raw clamp and sample pulses in both phase modes.
- R11: During reset, `fh1_o`, `fh1b_o`, `rst_pulse_o`, `blank_o`, `cds_loop_o` and `sh_loop_o` are 0, and `fh2_o` and `fh2b_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, `PIX_TICKS` ticks per pixel |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hd_i | input | 1 | Line reference pulse; its rising edge realigns the counter |
| std_pal_i | input | 1 | 0 selects the 1212-pixel line, 1 the 1236-pixel line |
| sens_b_i | input | 1 | 0 selects sensor type A, 1 type B |
| mirror_i | input | 1 | 0 normal readout, 1 mirror readout |
| phase_fix_i | input | 1 | 1 uses internal sampling phase, 0 uses the return inputs |
| cds_ret_i | input | 1 | Delayed clamp pulse returning from the external network |
| sh_ret_i | input | 1 | Delayed sample-hold pulse returning from the external network |
| fh1_o | output | 1 | Horizontal transfer phase 1 |
| fh2_o | output | 1 | Horizontal transfer phase 2 |
| fh1b_o | output | 1 | Second-pair transfer output 1, direction dependent |
| fh2b_o | output | 1 | Second-pair transfer output 2, direction dependent |
| rst_pulse_o | output | 1 | Charge reset pulse |
| blank_o | output | 1 | Horizontal blanking window |
| cds_loop_o | output | 1 | Raw clamp pulse sent to the external delay |
| sh_loop_o | output | 1 | Raw sample-hold pulse sent to the external delay |
| cds_o | output | 1 | Final clamp pulse |
| sh_o | output | 1 | Final sample-hold pulse |

## Verification
A wrong pixel count shows up within one line as a shifted or mis-spaced `blank_o` edge. The bench therefore measures blank periods and widths in every standard and sensor combination. It also times the blank rise after early and late reference pulses, which pins down the realignment edge to the clock. A wrong tick count or a wrong mirror select corrupts the transfer, reset or sampling pulses within a single pixel. A cycle-by-cycle reference model, driven by random mode changes, reference pulses and return-input noise, catches this in the next cycle.

// File: rtl/ccd_htg_pkg.sv
package ccd_htg_pkg;

    // Registered pulse bundle shared by the pulse shaper and the top.
    typedef struct packed {
        logic fh1;
        logic fh2;
        logic fh1b;
        logic fh2b;
        logic rst;
        logic cds;
        logic sh;
        logic blank;
    } hpulse_t;

    // Value held during reset: phase 2 parked high, everything else low.
    localparam hpulse_t PULSE_RST = '{
        fh1:   1'b0,
        fh2:   1'b1,
        fh1b:  1'b0,
        fh2b:  1'b1,
        rst:   1'b0,
        cds:   1'b0,
        sh:    1'b0,
        blank: 1'b0
    };

endpackage

// File: rtl/ccd_htg_counter.sv
module ccd_htg_counter #(
    parameter int unsigned PIX_TICKS = 4,
    parameter int unsigned LINE_NTSC = 1212,
    parameter int unsigned LINE_PAL  = 1236,
    parameter int unsigned PIX_W     = 11,
    parameter int unsigned SUB_W     = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hd_i,
    input  logic             std_pal_i,
    output logic [PIX_W-1:0] pix_o,
    output logic [SUB_W-1:0] sub_o
);

    localparam logic [PIX_W-1:0] LAST_N   = PIX_W'(LINE_NTSC - 1);
    localparam logic [PIX_W-1:0] LAST_P   = PIX_W'(LINE_PAL - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PIX_TICKS - 1);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic [SUB_W-1:0] sub;
        logic             hd;
    } cnt_t;

    cnt_t             cnt_d, cnt_q;
    logic [PIX_W-1:0] last_d;

    always_comb begin
        cnt_d    = cnt_q;
        cnt_d.hd = hd_i;
        last_d   = std_pal_i ? LAST_P : LAST_N;
        if (hd_i && !cnt_q.hd) begin
            // rising edge of the line reference: restart the line
            cnt_d.pix = '0;
            cnt_d.sub = '0;
        end else if (cnt_q.sub == SUB_LAST) begin
            cnt_d.sub = '0;
            // ">=" also recovers when the standard shrinks the line mid-count
            cnt_d.pix = (cnt_q.pix >= last_d) ? '0 : cnt_q.pix + 1'b1;
        end else begin
            cnt_d.sub = cnt_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pix_o = cnt_q.pix;
    assign sub_o = cnt_q.sub;

endmodule

// File: rtl/ccd_htg_window.sv
module ccd_htg_window #(
    parameter int unsigned PIX_W          = 11,
    parameter int unsigned BLANK_START_A  = 8,
    parameter int unsigned BLANK_START_B  = 3,
    parameter int unsigned BLANK_END_NTSC = 210,
    parameter int unsigned BLANK_END_PAL  = 234
) (
    input  logic [PIX_W-1:0] pix_i,
    input  logic             std_pal_i,
    input  logic             sens_b_i,
    output logic             blank_o
);

    localparam logic [PIX_W-1:0] START_A = PIX_W'(BLANK_START_A);
    localparam logic [PIX_W-1:0] START_B = PIX_W'(BLANK_START_B);
    localparam logic [PIX_W-1:0] END_N   = PIX_W'(BLANK_END_NTSC);
    localparam logic [PIX_W-1:0] END_P   = PIX_W'(BLANK_END_PAL);

    logic [PIX_W-1:0] start_d;
    logic [PIX_W-1:0] stop_d;

    // Sensor type moves the opening edge, TV standard moves the closing edge.
    always_comb begin
        start_d = sens_b_i  ? START_B : START_A;
        stop_d  = std_pal_i ? END_P   : END_N;
        blank_o = (pix_i >= start_d) && (pix_i < stop_d);
    end

endmodule

// File: rtl/ccd_htg_pulse.sv
module ccd_htg_pulse
    import ccd_htg_pkg::*;
#(
    parameter int unsigned PIX_TICKS = 4,
    parameter int unsigned SUB_W     = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SUB_W-1:0] sub_i,
    input  logic             blank_i,
    input  logic             mirror_i,
    input  logic             phase_fix_i,
    input  logic             cds_ret_i,
    input  logic             sh_ret_i,
    output hpulse_t          pls_o,
    output logic             cds_o,
    output logic             sh_o
);

    // PIX_TICKS must be even and at least 4 so reset, clamp and sample
    // each get a tick of their own.
    localparam logic [SUB_W-1:0] HALF     = SUB_W'(PIX_TICKS / 2);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PIX_TICKS - 1);

    hpulse_t pls_d, pls_q;

    always_comb begin
        pls_d       = pls_q;
        pls_d.fh1   = (sub_i < HALF);
        pls_d.fh2   = !(sub_i < HALF);
        pls_d.fh1b  = mirror_i ? pls_d.fh2 : pls_d.fh1;
        pls_d.fh2b  = mirror_i ? pls_d.fh1 : pls_d.fh2;
        pls_d.rst   = (sub_i < HALF);
        pls_d.cds   = (sub_i == HALF) && !blank_i;
        pls_d.sh    = (sub_i == SUB_LAST) && !blank_i;
        pls_d.blank = blank_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pls_q <= PULSE_RST;
        end else begin
            pls_q <= pls_d;
        end
    end

    assign pls_o = pls_q;

    // Final sampling pulses: internal phase, or the externally delayed copy.
    always_comb begin
        cds_o = phase_fix_i ? pls_q.cds : cds_ret_i;
        sh_o  = phase_fix_i ? pls_q.sh  : sh_ret_i;
    end

endmodule

// File: rtl/ccd_htg.sv
module ccd_htg
    import ccd_htg_pkg::*;
#(
    parameter int unsigned PIX_TICKS      = 4,
    parameter int unsigned LINE_NTSC      = 1212,
    parameter int unsigned LINE_PAL       = 1236,
    parameter int unsigned BLANK_START_A  = 8,
    parameter int unsigned BLANK_START_B  = 3,
    parameter int unsigned BLANK_END_NTSC = 210,
    parameter int unsigned BLANK_END_PAL  = 234
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hd_i,
    input  logic std_pal_i,
    input  logic sens_b_i,
    input  logic mirror_i,
    input  logic phase_fix_i,
    input  logic cds_ret_i,
    input  logic sh_ret_i,
    output logic fh1_o,
    output logic fh2_o,
    output logic fh1b_o,
    output logic fh2b_o,
    output logic rst_pulse_o,
    output logic blank_o,
    output logic cds_loop_o,
    output logic sh_loop_o,
    output logic cds_o,
    output logic sh_o
);

    localparam int unsigned LINE_MAX = (LINE_PAL > LINE_NTSC) ? LINE_PAL : LINE_NTSC;
    localparam int unsigned PIX_W    = $clog2(LINE_MAX);
    localparam int unsigned SUB_W    = (PIX_TICKS > 2) ? $clog2(PIX_TICKS) : 1;

    logic [PIX_W-1:0] pix_w;
    logic [SUB_W-1:0] sub_w;
    logic             blank_w;
    hpulse_t          pls_w;

    ccd_htg_counter #(
        .PIX_TICKS (PIX_TICKS),
        .LINE_NTSC (LINE_NTSC),
        .LINE_PAL  (LINE_PAL),
        .PIX_W     (PIX_W),
        .SUB_W     (SUB_W)
    ) u_counter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hd_i      (hd_i),
        .std_pal_i (std_pal_i),
        .pix_o     (pix_w),
        .sub_o     (sub_w)
    );

    ccd_htg_window #(
        .PIX_W          (PIX_W),
        .BLANK_START_A  (BLANK_START_A),
        .BLANK_START_B  (BLANK_START_B),
        .BLANK_END_NTSC (BLANK_END_NTSC),
        .BLANK_END_PAL  (BLANK_END_PAL)
    ) u_window (
        .pix_i     (pix_w),
        .std_pal_i (std_pal_i),
        .sens_b_i  (sens_b_i),
        .blank_o   (blank_w)
    );

    ccd_htg_pulse #(
        .PIX_TICKS (PIX_TICKS),
        .SUB_W     (SUB_W)
    ) u_pulse (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sub_i       (sub_w),
        .blank_i     (blank_w),
        .mirror_i    (mirror_i),
        .phase_fix_i (phase_fix_i),
        .cds_ret_i   (cds_ret_i),
        .sh_ret_i    (sh_ret_i),
        .pls_o       (pls_w),
        .cds_o       (cds_o),
        .sh_o        (sh_o)
    );

    assign fh1_o       = pls_w.fh1;
    assign fh2_o       = pls_w.fh2;
    assign fh1b_o      = pls_w.fh1b;
    assign fh2b_o      = pls_w.fh2b;
    assign rst_pulse_o = pls_w.rst;
    assign blank_o     = pls_w.blank;
    assign cds_loop_o  = pls_w.cds;
    assign sh_loop_o   = pls_w.sh;

endmodule

// File: rtl/ccd_htg_chk.sv
module ccd_htg_chk #(
    parameter int unsigned PIX_W = 11,
    parameter int unsigned SUB_W = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             hd_i,
    input logic             mirror_i,
    input logic             fh1_o,
    input logic             fh2_o,
    input logic             fh1b_o,
    input logic             fh2b_o,
    input logic             rst_pulse_o,
    input logic             blank_o,
    input logic             cds_loop_o,
    input logic             sh_loop_o,
    input logic [PIX_W-1:0] pix_i,
    input logic [SUB_W-1:0] sub_i
);

    // Properties that look one edge back wait for one edge after reset.
    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    // R2
    fh_no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fh1_o != fh2_o);

    // R3
    b_pair_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        !$past(mirror_i) |-> (fh1b_o == fh1_o && fh2b_o == fh2_o));

    // R3
    b_pair_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        $past(mirror_i) |-> (fh1b_o == fh2_o && fh2b_o == fh1_o));

    // R4
    pulse_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({rst_pulse_o, cds_loop_o, sh_loop_o}) <= 1);

    // R6
    blank_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blank_o |-> (!cds_loop_o && !sh_loop_o));

    // R7
    hd_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        (hd_i && !$past(hd_i)) |=> (pix_i == '0 && sub_i == '0));

endmodule

bind ccd_htg ccd_htg_chk #(
    .PIX_W (PIX_W),
    .SUB_W (SUB_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hd_i        (hd_i),
    .mirror_i    (mirror_i),
    .fh1_o       (fh1_o),
    .fh2_o       (fh2_o),
    .fh1b_o      (fh1b_o),
    .fh2b_o      (fh2b_o),
    .rst_pulse_o (rst_pulse_o),
    .blank_o     (blank_o),
    .cds_loop_o  (cds_loop_o),
    .sh_loop_o   (sh_loop_o),
    .pix_i       (pix_w),
    .sub_i       (sub_w)
);

// File: tb/ccd_htg_bench.sv
module ccd_htg_bench;

    localparam int PT = 4;
    localparam int LN = 1212;
    localparam int LP = 1236;
    localparam int SA = 8;
    localparam int SB = 3;
    localparam int EN = 210;
    localparam int EP = 234;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hd = 1'b0, pal = 1'b0, typb = 1'b0, mir = 1'b0, fix = 1'b1;
    logic cret = 1'b0, sret = 1'b0;
    logic fh1, fh2, fh1b, fh2b, rstp, blank, cdsl, shl, cds, sh;

    always #10 clk = ~clk;

    ccd_htg u_ccd_htg (
        .clk_i(clk), .rst_ni(rst_n), .hd_i(hd), .std_pal_i(pal), .sens_b_i(typb),
        .mirror_i(mir), .phase_fix_i(fix), .cds_ret_i(cret), .sh_ret_i(sret),
        .fh1_o(fh1), .fh2_o(fh2), .fh1b_o(fh1b), .fh2b_o(fh2b), .rst_pulse_o(rstp),
        .blank_o(blank), .cds_loop_o(cdsl), .sh_loop_o(shl), .cds_o(cds), .sh_o(sh)
    );

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  cmp_on = 1'b0;
    bit  loop_mode = 1'b0;
    bit  rnd_ret = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_blank(input int p, input bit is_pal, input bit is_b);
        int st, en;
        st = is_b ? SB : SA;
        en = is_pal ? EP : EN;
        return (p >= st) && (p < en);
    endfunction

    // Reference model built from the requirements.
    int m_p, m_s;
    bit m_hd;
    bit e_fh1, e_fh2, e_fh1b, e_fh2b, e_rst, e_cds, e_sh, e_blk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p = 0; m_s = 0; m_hd = 0;
            e_fh1 = 0; e_fh2 = 1; e_fh1b = 0; e_fh2b = 1;
            e_rst = 0; e_cds = 0; e_sh = 0; e_blk = 0;
        end else begin
            bit b;
            int len;
            b      = exp_blank(m_p, pal, typb);
            e_fh1  = (m_s < PT / 2);
            e_fh2  = !e_fh1;
            e_fh1b = mir ? e_fh2 : e_fh1;
            e_fh2b = mir ? e_fh1 : e_fh2;
            e_rst  = (m_s < PT / 2);
            e_cds  = (m_s == PT / 2) && !b;
            e_sh   = (m_s == PT - 1) && !b;
            e_blk  = b;
            len    = pal ? LP : LN;
            if (hd && !m_hd) begin
                m_p = 0; m_s = 0;
            end else if (m_s == PT - 1) begin
                m_s = 0;
                m_p = (m_p >= len - 1) ? 0 : m_p + 1;
            end else begin
                m_s = m_s + 1;
            end
            m_hd = hd;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    initial forever begin
        @(negedge clk);
        #2;
        if (rst_n && cmp_on) begin
            chk(fh1 == e_fh1,   "R2",  int'(fh1),  int'(e_fh1));
            chk(fh2 == e_fh2,   "R2",  int'(fh2),  int'(e_fh2));
            chk(fh1b == e_fh1b, "R3",  int'(fh1b), int'(e_fh1b));
            chk(fh2b == e_fh2b, "R3",  int'(fh2b), int'(e_fh2b));
            chk(rstp == e_rst,  "R4",  int'(rstp), int'(e_rst));
            chk(cdsl == e_cds,  "R10", int'(cdsl), int'(e_cds));
            chk(shl == e_sh,    "R10", int'(shl),  int'(e_sh));
            chk(blank == e_blk, "R5",  int'(blank), int'(e_blk));
            chk(cds == (fix ? e_cds : cret), fix ? "R8" : "R9", int'(cds), int'(fix ? e_cds : cret));
            chk(sh == (fix ? e_sh : sret),   fix ? "R8" : "R9", int'(sh),  int'(fix ? e_sh : sret));
        end
    end

    // Return-input driver: external two-clock delay loop or random noise.
    logic [1:0] dly_c = '0, dly_s = '0;
    initial forever begin
        @(negedge clk);
        if (loop_mode) begin
            cret  = dly_c[1];
            sret  = dly_s[1];
            dly_c = {dly_c[0], cdsl};
            dly_s = {dly_s[0], shl};
        end else if (rnd_ret) begin
            cret = ($urandom & 1) != 0;
            sret = ($urandom & 2) != 0;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    task automatic wait_rise(output int cyc);
        bit prev;
        prev = blank;
        cyc  = 0;
        forever begin
            @(negedge clk);
            #2;
            cyc++;
            if (!prev && blank) return;
            prev = blank;
        end
    endtask

    task automatic blank_width(output int n, output int pulses, output int rises);
        int  d;
        bit  pf;
        wait_rise(d);
        n = 1; pulses = 0; rises = 0; pf = fh1;
        forever begin
            @(negedge clk);
            #2;
            if (!blank) return;
            n++;
            if (cdsl || shl) pulses++;
            if (fh1 && !pf) rises++;
            pf = fh1;
        end
    endtask

    task automatic hd_realign(output int c);
        bit prev;
        prev = 1'b1;
        @(negedge clk);
        hd = 1'b1;
        @(posedge clk);
        c = 0;
        forever begin
            @(posedge clk);
            c++;
            @(negedge clk);
            if (c == 3) hd = 1'b0;
            #2;
            if (!prev && blank) return;
            prev = blank;
            if (c > 20000) return;
        end
    endtask

    initial begin
        int d, n, p, r;
        bit h [64];
        void'($urandom(32'd2024));

        // R11: reset state
        repeat (3) @(negedge clk);
        #2;
        chk(fh1 == 1'b0,  "R11", int'(fh1),  0);
        chk(fh2 == 1'b1,  "R11", int'(fh2),  1);
        chk(fh1b == 1'b0, "R11", int'(fh1b), 0);
        chk(fh2b == 1'b1, "R11", int'(fh2b), 1);
        chk(rstp == 1'b0, "R11", int'(rstp), 0);
        chk(blank == 1'b0, "R11", int'(blank), 0);
        chk(cdsl == 1'b0, "R11", int'(cdsl), 0);
        chk(shl == 1'b0,  "R11", int'(shl),  0);
        @(negedge clk);
        rst_n  = 1'b1;
        cmp_on = 1'b1;

        // R1: line length, both standards
        wait_rise(d);
        wait_rise(n);
        chk(n == PT * LN, "R1", n, PT * LN);
        @(negedge clk); pal = 1'b1;
        wait_rise(d);
        wait_rise(n);
        chk(n == PT * LP, "R1", n, PT * LP);

        // R5 / R6: blank width, suppressed sampling, running transfer clock
        wait_rise(d);
        blank_width(n, p, r);
        chk(n == PT * (EP - SA), "R5", n, PT * (EP - SA));
        chk(p == 0, "R6", p, 0);
        chk(r == EP - SA - 1 || r == EP - SA, "R6", r, EP - SA);
        @(negedge clk); pal = 1'b0; typb = 1'b1;
        wait_rise(d);
        blank_width(n, p, r);
        chk(n == PT * (EN - SB), "R5", n, PT * (EN - SB));
        chk(p == 0, "R6", p, 0);

        // R7: early and late reference pulses
        @(negedge clk); typb = 1'b0;
        wait_rise(d);
        repeat (2000) @(negedge clk);
        hd_realign(d);
        chk(d == 1 + SA * PT, "R7", d, 1 + SA * PT);
        wait_rise(d);
        repeat (20) @(negedge clk);
        hd_realign(d);
        chk(d == 1 + SA * PT, "R7", d, 1 + SA * PT);
        wait_rise(n);
        chk(n == PT * LN, "R1", n, PT * LN);

        // R3: mirror toggle swaps the second pair
        @(negedge clk); mir = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #2;
            chk(fh1b == fh2 && fh2b == fh1, "R3", int'(fh1b), int'(fh2));
        end
        @(negedge clk); mir = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #2;
            chk(fh1b == fh1 && fh2b == fh2, "R3", int'(fh1b), int'(fh1));
        end

        // R8: fixed phase ignores noisy return inputs
        rnd_ret = 1'b1;
        wait_rise(d);
        repeat (PT * 300) @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); #2;
            chk(cds == cdsl && sh == shl, "R8", int'(cds), int'(cdsl));
        end

        // R9 / R10: two-clock external delay loop
        rnd_ret = 1'b0;
        loop_mode = 1'b1;
        @(negedge clk); fix = 1'b0;
        repeat (4) @(negedge clk);
        p = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); #2;
            h[i] = cdsl;
            if (cdsl) p++;
            if (i >= 2) chk(cds == h[i-2], "R9", int'(cds), int'(h[i-2]));
        end
        chk(p == 64 / PT, "R10", p, 64 / PT);

        // Random phase: modes, reference pulses and return noise
        loop_mode = 1'b0;
        rnd_ret = 1'b1;
        for (int i = 0; i < 24000; i++) begin
            @(negedge clk);
            if ($urandom % 1500 == 0) pal  = ($urandom & 1) != 0;
            if ($urandom % 1500 == 0) typb = ($urandom & 1) != 0;
            if ($urandom % 700 == 0)  mir  = !mir;
            if ($urandom % 900 == 0)  fix  = !fix;
            hd = ($urandom % 2500 == 0);
        end
        hd = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule